// File: doc/BRIEF.md
# Chainable Eight-Way Priority Encoder

This block turns eight request lines into the three-bit index of the most important request present. Request 7 is the most important and request 0 the least. Every pin uses low-true signalling: a request is present when its line is 0, the block is switched on when its enable line is 0, and each output says "yes" by going to 0. The index is presented inverted, so the winning request number `k` appears on the code pins as `~k`.

Besides the index, the block drives two flags. The first tells the outside world that this stage saw at least one request. The second tells the next, less important stage that this stage is switched on but has nothing to report, so that stage may answer in its place. Tying the second flag of one encoder to the enable of the next builds a longer priority chain. The block has no clock and no storage: every output follows its inputs through gates alone.

Top module: `prio_chain_enc8`

## Requirements
- R1: All pins are low-true: a request line at 0 means "requesting", `en_in_n` at 0 means "enabled", and each output at 0 means "asserted".
- R2: While `en_in_n` is 1, `code_n` is 3'b111 and `hit_n` and `pass_n` are both 1, whatever the requests are.
- R3: When enabled, the highest-numbered request line at 0 decides the result, and lower-numbered request lines have no effect on any output.
- R4: When enabled with a winning request `k`, `code_n` equals the bitwise inverse of `k` in three bits: request 7 gives 3'b000, request 4 gives 3'b011, request 0 gives 3'b111.
- R5: `hit_n` is 0 exactly when `en_in_n` is 0 and at least one bit of `req_n` is 0.
- R6: `pass_n` is 0 exactly when `en_in_n` is 0 and every bit of `req_n` is 1.
- R7: When enabled with no request, `code_n` is 3'b111, `hit_n` is 1 and `pass_n` is 0.
- R8: `hit_n` and `pass_n` are never 0 together.
- R9: The outputs depend only on the present inputs, with no clock and no stored state: a change of input is seen at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in_n | input | 1 | Stage enable, 0 = enabled |
| req_n | input | 8 | Request lines, bit i at 0 = request i present |
| code_n | output | 3 | Inverted index of the winning request |
| hit_n | output | 1 | 0 = enabled and at least one request present |
| pass_n | output | 1 | 0 = enabled and no request present; drives the next stage's enable |

## Verification
The hardest case to reach from the ports is a low-numbered request that must be shown to have no effect while a higher one is present, because a wrongly wired priority mask only shows itself for particular pairs of active lines. The stimulus therefore walks every one of the 512 combinations of enable and request and compares each against a reference model that scans from request 7 downward. A short table of directed vectors first pins down the named corners: disabled with all requests active, enabled and idle, a lone request at each end, and a crowded pattern in which the winner sits in the middle.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int unsigned NREQ  = 8;
  localparam int unsigned IDX_W = $clog2(NREQ);

  typedef logic [NREQ-1:0]  req_vec_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/req_frontend.sv
// Converts the low-true request lines to high-true and gates them with the enable.
module req_frontend
  import prio_enc_pkg::*;
(
  input  logic     en_in_n,
  input  req_vec_t req_n,
  output req_vec_t act,
  output logic     en
);
  assign en = ~en_in_n;

  for (genvar i = 0; i < NREQ; i++) begin : g_bit
    assign act[i] = ~req_n[i] & en;
  end

  always_comb begin
    // R2
    disabled_quiet_chk: assert (en || act == '0)
      else $error("requests leak through while disabled");
  end
endmodule

// File: rtl/prio_onehot.sv
// Keeps only the highest-numbered active request.
module prio_onehot
  import prio_enc_pkg::*;
(
  input  req_vec_t act,
  output req_vec_t grant
);
  assign grant[NREQ-1] = act[NREQ-1];

  for (genvar i = 0; i < NREQ-1; i++) begin : g_mask
    assign grant[i] = act[i] & ~(|act[NREQ-1:i+1]);
  end

  always_comb begin
    // R3
    single_grant_chk: assert ($onehot0(grant))
      else $error("more than one request granted");
    // R5
    grant_if_any_chk: assert ((act == '0) == (grant == '0))
      else $error("grant presence disagrees with requests");
  end
endmodule

// File: rtl/onehot_index.sv
// Turns a one-hot grant into its binary index by OR-ing the matching positions.
module onehot_index
  import prio_enc_pkg::*;
(
  input  req_vec_t grant,
  output idx_t     idx
);
  always_comb begin
    idx = '0;
    for (int b = 0; b < IDX_W; b++) begin
      for (int i = 0; i < NREQ; i++) begin
        if (((i >> b) & 1) == 1) idx[b] = idx[b] | grant[i];
      end
    end
  end
endmodule

// File: rtl/prio_chain_enc8.sv
module prio_chain_enc8
  import prio_enc_pkg::*;
(
  input  logic       en_in_n,
  input  logic [7:0] req_n,
  output logic [2:0] code_n,
  output logic       hit_n,
  output logic       pass_n
);
  req_vec_t act;
  req_vec_t grant;
  idx_t     idx;
  logic     en;
  logic     any;

  req_frontend u_front (
    .en_in_n (en_in_n),
    .req_n   (req_n),
    .act     (act),
    .en      (en)
  );

  prio_onehot u_sel (
    .act   (act),
    .grant (grant)
  );

  onehot_index u_idx (
    .grant (grant),
    .idx   (idx)
  );

  assign any    = |grant;
  assign code_n = ~idx;
  assign hit_n  = ~any;
  assign pass_n = ~(en & ~any);

  always_comb begin
    // R8
    flags_exclusive_chk: assert (hit_n || pass_n)
      else $error("both chain flags asserted");
    // R2
    off_outputs_high_chk: assert (!en_in_n || (code_n == 3'b111 && hit_n && pass_n))
      else $error("outputs active while disabled");
    // R3
    winner_present_chk: assert (hit_n || req_n[~code_n] == 1'b0)
      else $error("reported request is not present");
    // R3
    no_higher_chk: assert (hit_n || (~code_n == 3'd7) || ((~req_n) >> (~code_n + 3'd1)) == 8'd0)
      else $error("a higher request was passed over");
    // R6
    idle_pass_chk: assert (en_in_n || (req_n != 8'hFF) || (!pass_n && code_n == 3'b111))
      else $error("enabled idle stage does not pass on");
  end
endmodule

// File: tb/tb_prio_chain_enc8.sv
module tb_prio_chain_enc8;
  logic       clk = 1'b0;
  logic       en_in_n;
  logic [7:0] req_n;
  logic [2:0] code_n;
  logic       hit_n;
  logic       pass_n;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_chain_enc8 dut (
    .en_in_n (en_in_n),
    .req_n   (req_n),
    .code_n  (code_n),
    .hit_n   (hit_n),
    .pass_n  (pass_n)
  );

  // {en_in_n, req_n, code_n, hit_n, pass_n}
  localparam logic [13:0] TBL [10] = '{
    14'b1_00000000_111_1_1,  // R2 disabled, all requesting
    14'b0_11111111_111_1_0,  // R7 enabled idle
    14'b0_01111111_000_0_1,  // R4 request 7
    14'b0_11111110_111_0_1,  // R4 request 0
    14'b0_00000000_000_0_1,  // R3 all requesting
    14'b0_11101111_011_0_1,  // R4 request 4
    14'b0_11100000_011_0_1,  // R3 4 beats 3..0
    14'b0_11111101_110_0_1,  // R1 request 1
    14'b0_10111111_001_0_1,  // R4 request 6
    14'b1_11111111_111_1_1   // R2 disabled idle
  };

  function automatic logic [4:0] ref_model(input logic e_n, input logic [7:0] r_n);
    logic [2:0] c;
    logic found;
    c = 3'b111;
    found = 1'b0;
    if (!e_n) begin
      for (int i = 7; i >= 0; i--) begin
        if (!found && r_n[i] == 1'b0) begin
          c = ~i[2:0];
          found = 1'b1;
        end
      end
    end
    return {c, ~(found), ~((!e_n) && !found)};
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s en_n=%b req_n=%b got=%b expected=%b", tag, en_in_n, req_n, got, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset-like start: stage disabled
    en_in_n = 1'b1;
    req_n   = 8'hFF;
    @(negedge clk);
    check("R2 initial disabled", {code_n, hit_n, pass_n}, 5'b111_1_1);

    foreach (TBL[k]) begin
      @(negedge clk);
      en_in_n = TBL[k][13];
      req_n   = TBL[k][12:5];
      #1;
      check("R1 R3 R4 directed", {code_n, hit_n, pass_n}, TBL[k][4:0]);
    end

    // R9: change between edges, no clock edge in between
    @(posedge clk);
    #3;
    en_in_n = 1'b0;
    req_n   = 8'b11110111;
    #1;
    check("R9 no clock needed", {code_n, hit_n, pass_n}, 5'b100_0_1);
    req_n   = 8'b11111111;
    #1;
    check("R9 follows input", {code_n, hit_n, pass_n}, 5'b111_1_0);

    // R3: low request toggled under a high one has no effect
    req_n = 8'b11011111;
    #1;
    check("R3 request 5 alone", {code_n, hit_n, pass_n}, 5'b010_0_1);
    req_n = 8'b11010000;
    #1;
    check("R3 lower ignored", {code_n, hit_n, pass_n}, 5'b010_0_1);

    // exhaustive sweep
    for (int v = 0; v < 512; v++) begin
      logic [4:0] exp;
      @(negedge clk);
      en_in_n = v[8];
      req_n   = v[7:0];
      #1;
      exp = ref_model(en_in_n, req_n);
      check("R4 R3 code", {code_n, 2'b00}, {exp[4:2], 2'b00});
      check("R5 hit", {4'b0, hit_n}, {4'b0, exp[1]});
      check("R6 pass", {4'b0, pass_n}, {4'b0, exp[0]});
      check("R8 exclusive", {4'b0, hit_n | pass_n}, 5'b00001);
      if (en_in_n) check("R2 disabled", {code_n, hit_n, pass_n}, 5'b111_1_1);
      if (!en_in_n && req_n == 8'hFF) check("R7 idle", {code_n, hit_n, pass_n}, 5'b111_1_0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule